// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a bus master for three-wire-plus-select serial EEPROMs organised as 16-bit words (Microwire style). One request hands it a first word address, a number of words and a half-period setting for the serial clock. The block then fetches the words one after another. Each word gets its own complete read command frame. Every fetched word is presented on a parallel output with a one-cycle valid strobe and its position within the run.

The serial clock is made from the system clock. Each high phase and each low phase lasts a programmable number of system cycles. Outgoing data moves only while the serial clock is low. Incoming data is taken in the last system cycle of each high phase, so the memory has the whole high phase to drive its output. Between frames the select line drops, and one low-high-low clock pulse is run with select inactive.

The address width is a parameter, 6 or 8 bits, to suit the two common device sizes. Only reading is supported.

Top module: `mw_seq_reader`

## Requirements
- R1: After reset `csel`, `sclk`, `mosi`, `busy`, `done` and `wordValid` are all low.
- R2: Each frame raises `csel` while `sclk` is low. One whole serial clock period with `mosi` low passes before the first command bit, so the start bit is sampled on the second rising `sclk` edge of the frame.
- R3: After the leading idle period, the bits sent on `mosi` are 1 (start), then 1, 0 (the read opcode), then the word address with its most significant bit first, ADDR_W bits in all.
- R4: Each frame has exactly 17 rising `sclk` edges after the address. Of the 17 bits shifted in, the first (the memory's dummy zero) is discarded. `wordData` carries the remaining 16 bits, with the first received bit in bit 15. `wordValid` is high for one cycle per word.
- R5: Word i of a run is read from address (start + i) modulo 2^ADDR_W and reported with `wordIdx` = i. A run of N words produces exactly N frames.
- R6: After each frame, `csel` goes low and `sclk` makes exactly one low-high-low pulse with `csel` low before the next frame or the end of the run.
- R7: Every `sclk` high phase lasts max(`halfPeriod`,1) system cycles, and so does every low phase inside a frame. `mosi` never changes while `sclk` is high.
- R8: `busy` rises in the cycle after a request with a non-zero count is accepted and stays high until the last word has been delivered. `done` pulses for one cycle as `busy` falls. `csel` is only high while `busy` is high. Requests made while busy are ignored.
- R9: A request with a count of zero gives a `done` pulse in the next cycle, never raises `busy` and produces no `csel` activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, taken while idle |
| reqAddr | input | ADDR_W | First word address |
| reqCount | input | CNT_W | Number of words to read |
| halfPeriod | input | DIV_W | System cycles per serial clock phase (0 acts as 1) |
| miso | input | 1 | Serial data from the memory |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| csel | output | 1 | Memory chip select, active high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the memory |
| wordValid | output | 1 | One-cycle strobe for a fetched word |
| wordData | output | 16 | Fetched word |
| wordIdx | output | CNT_W | Position of the word within the run |

## Verification
A behavioural memory model on the serial pins decodes each frame and answers with a word computed from the received address. The checks cover command bits, address order, dummy-bit removal and data alignment. Random runs vary the start address, the length of the run and the clock half-period, including the zero setting. The half-period variation separates correct phase timing from timing that works only at one divider value. Directed runs cover a single word, a run that crosses the top of the address space (which exposes missing modulo wrap), a zero-length run, and a request injected mid-run, which shows whether a busy controller really ignores new requests.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int DATA_W     = 16;
  localparam int READ_BITS  = DATA_W + 1;
  localparam int ADDR_SLOT0 = 4;
  localparam int SLOT_W     = 5;

  typedef struct packed {
    logic              load;
    logic              shift;
    logic              capture;
    logic              advance;
    logic [SLOT_W-1:0] slot;
  } mwStrobe_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqZero,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             lastWord,
  output mwStrobe_t        strb,
  output logic             busy,
  output logic             done,
  output logic             csel,
  output logic             sclk
);
  localparam int RD_FIRST = ADDR_SLOT0 + ADDR_W;
  localparam int RD_LAST  = RD_FIRST + READ_BITS - 1;
  localparam int FRAME_PH = 2 * (RD_LAST + 1);
  localparam int TOTAL_PH = FRAME_PH + 3;
  localparam int PH_W     = $clog2(TOTAL_PH + 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t        state;
  logic [DIV_W-1:0]  tmr;
  logic [DIV_W-1:0]  hpM1;
  logic [PH_W-1:0]   ph;
  logic              doneQ;
  logic              phaseEnd;
  logic              inFrame;
  logic              frameEnd;
  logic [SLOT_W-1:0] slotIdx;

  assign busy     = (state == ST_RUN);
  assign phaseEnd = busy && (tmr == hpM1);
  assign inFrame  = ph < PH_W'(FRAME_PH);
  assign frameEnd = phaseEnd && (ph == PH_W'(TOTAL_PH - 1));
  assign slotIdx  = SLOT_W'(ph >> 1);

  assign csel = busy && inFrame;
  assign sclk = busy && (inFrame ? ph[0] : (ph == PH_W'(FRAME_PH + 1)));
  assign done = doneQ;

  always_comb begin
    strb.load    = !busy && reqValid && !reqZero;
    strb.shift   = phaseEnd && inFrame && ph[0] && (slotIdx >= SLOT_W'(RD_FIRST));
    strb.capture = strb.shift && (slotIdx == SLOT_W'(RD_LAST));
    strb.advance = frameEnd && !lastWord;
    strb.slot    = slotIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tmr   <= '0;
      hpM1  <= '0;
      ph    <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busy) begin
        if (reqValid) begin
          if (reqZero) begin
            doneQ <= 1'b1;
          end else begin
            state <= ST_RUN;
            tmr   <= '0;
            ph    <= '0;
            hpM1  <= (halfPeriod == '0) ? '0 : halfPeriod - 1'b1;
          end
        end
      end else if (phaseEnd) begin
        tmr <= '0;
        if (frameEnd) begin
          ph <= '0;
          if (lastWord) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    csel |-> busy); // R8
  AST_CS_RISE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csel) |-> !sclk); // R2
  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !phaseEnd) |=> $stable(sclk)); // R7
  AST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> (sclk && csel)); // R4
  AST_ZERO_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqZero) |=> (done && !busy && !csel)); // R9
endmodule

// File: rtl/mw_dpath.sv
module mw_dpath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              miso,
  output logic              mosi,
  output logic              lastWord,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [CNT_W-1:0]  wordIdx
);
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] shReg;
  logic [ADDR_W-1:0] addrHit;

  for (genvar g = 0; g < ADDR_W; g++) begin : gAddrBit
    assign addrHit[g] = addr[g] && (strb.slot == SLOT_W'(ADDR_SLOT0 + ADDR_W - 1 - g));
  end

  assign mosi     = (|addrHit) || (strb.slot == SLOT_W'(1)) || (strb.slot == SLOT_W'(2));
  assign lastWord = (remain == CNT_W'(1));
  assign wordIdx  = idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= '0;
      idx       <= '0;
      remain    <= '0;
      shReg     <= '0;
      wordData  <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (strb.load) begin
        addr   <= reqAddr;
        idx    <= '0;
        remain <= reqCount;
      end else if (strb.advance) begin
        addr   <= addr + 1'b1;
        idx    <= idx + 1'b1;
        remain <= remain - 1'b1;
      end
      if (strb.shift) begin
        shReg <= {shReg[DATA_W-2:0], miso};
      end
      if (strb.capture) begin
        wordData  <= {shReg[DATA_W-2:0], miso};
        wordValid <= 1'b1;
      end
    end
  end

  AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R4
  AST_WORD_REMAIN: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (remain != '0)); // R5
endmodule

// File: rtl/mw_seq_reader.sv
module mw_seq_reader
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              csel,
  output logic              sclk,
  output logic              mosi,
  output logic              wordValid,
  output logic [15:0]       wordData,
  output logic [CNT_W-1:0]  wordIdx
);
  mwStrobe_t strb;
  logic      lastWord;

  mw_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZero(reqCount == '0),
    .halfPeriod(halfPeriod), .lastWord(lastWord), .strb(strb),
    .busy(busy), .done(done), .csel(csel), .sclk(sclk)
  );

  mw_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqCount(reqCount),
    .miso(miso), .mosi(mosi), .lastWord(lastWord), .wordValid(wordValid),
    .wordData(wordData), .wordIdx(wordIdx)
  );

  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi)); // R7
endmodule

// File: tb/tb_mw_seq_reader.sv
module tb_mw_seq_reader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [CW-1:0] reqCount = '0;
  logic [DW-1:0] halfPeriod = '0;
  logic miso = 1'b1;
  logic busy, done, csel, sclk, mosi, wordValid;
  logic [15:0] wordData;
  logic [CW-1:0] wordIdx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit armed = 0;

  int curStart, curCount, curHp;
  int framesSeen, gotWords, lowRises, csRises, hiRun;

  int riseCnt, startRise, bitsIn, rdK;
  bit gotStart;
  logic [1:0] opBits;
  logic [AW-1:0] rxAddr;

  mw_seq_reader #(.ADDR_W(AW), .CNT_W(CW), .DIV_W(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCount(reqCount), .halfPeriod(halfPeriod), .miso(miso), .busy(busy),
    .done(done), .csel(csel), .sclk(sclk), .mosi(mosi), .wordValid(wordValid),
    .wordData(wordData), .wordIdx(wordIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memWord(input int a);
    return 16'((a * 40503 + 7995) ^ (a << 9));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: frame start, end and serial bits
  always @(posedge csel) if (armed) begin
    csRises++;
    if (framesSeen > 0) chk(lowRises == 1, "R6 trailer pulses", lowRises, 1);
    lowRises = 0;
    riseCnt = 0; gotStart = 0; bitsIn = 0; rdK = 0; opBits = '0; rxAddr = '0;
    miso = 1'b1;
  end

  always @(negedge csel) if (armed) begin
    chk(gotStart && startRise == 2, "R2 start bit edge", startRise, 2);
    chk(opBits == 2'b10, "R3 opcode", opBits, 2);
    chk(int'(rxAddr) == ((curStart + framesSeen) & AMASK), "R3 address",
        rxAddr, (curStart + framesSeen) & AMASK);
    chk(rdK == 17, "R4 read clocks", rdK, 17);
    framesSeen++;
    miso = 1'b1;
  end

  always @(posedge sclk) if (armed) begin
    if (!csel) begin
      lowRises++;
    end else begin
      riseCnt++;
      if (!gotStart) begin
        if (mosi) begin
          gotStart = 1;
          startRise = riseCnt;
        end
      end else if (bitsIn < 2 + AW) begin
        if (bitsIn < 2) opBits = {opBits[0], mosi};
        else rxAddr = {rxAddr[AW-2:0], mosi};
        bitsIn++;
      end else begin
        if (rdK == 0) miso = 1'b0;
        else if (rdK <= 16) miso = memWord(int'(rxAddr))[16 - rdK];
        else miso = 1'b1;
        rdK++;
      end
    end
  end

  // output monitor and phase timing
  always @(negedge clk) if (armed) begin
    cycles++;
    if (wordValid) begin
      chk(wordData == memWord((curStart + gotWords) & AMASK), "R4 word data",
          wordData, memWord((curStart + gotWords) & AMASK));
      chk(int'(wordIdx) == gotWords, "R5 word index", wordIdx, gotWords);
      gotWords++;
    end
    if (sclk) hiRun++;
    else if (hiRun > 0) begin
      chk(hiRun == curHp, "R7 high phase length", hiRun, curHp);
      hiRun = 0;
    end
    if (csel) chk(busy, "R8 csel only while busy", busy, 1);
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic runReq(input int start, input int cnt, input int hp, input bit interfere);
    int n;
    int cs0;
    @(negedge clk);
    curStart = start; curCount = cnt; curHp = (hp == 0) ? 1 : hp;
    framesSeen = 0; gotWords = 0; lowRises = 0; cs0 = csRises;
    reqValid = 1'b1; reqAddr = AW'(start); reqCount = CW'(cnt); halfPeriod = DW'(hp);
    @(negedge clk);
    reqValid = 1'b0;
    if (cnt == 0) begin
      chk(done == 1'b1, "R9 immediate done", done, 1);
      chk(busy == 1'b0, "R9 no busy", busy, 0);
      repeat (30) @(negedge clk);
      chk(csRises == cs0, "R9 no select activity", csRises - cs0, 0);
      return;
    end
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (interfere) begin
      repeat (40) @(negedge clk);
      reqValid = 1'b1; reqAddr = AW'(start + 5); reqCount = 8'd7;
      @(negedge clk);
      reqValid = 1'b0;
    end
    n = 0;
    while (!done && n < 100000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    chk(gotWords == cnt, "R8 word count", gotWords, cnt);
    chk(framesSeen == cnt, "R5 frame count", framesSeen, cnt);
    chk(lowRises == 1, "R6 final trailer", lowRises, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd24681));
    curHp = 1;
    repeat (3) @(negedge clk);
    chk(!csel && !sclk && !mosi, "R1 serial pins reset", {csel, sclk, mosi}, 0);
    chk(!busy && !done && !wordValid, "R1 status reset", {busy, done, wordValid}, 0);
    rstN = 1'b1;
    armed = 1;
    runReq(0, 1, 1, 0);
    runReq(62, 4, 2, 0);       // R5 address wrap
    runReq(10, 0, 3, 0);       // R9
    runReq(20, 3, 1, 1);       // R8 request ignored while busy
    runReq(5, 2, 0, 0);        // R7 zero half period acts as one
    runReq(63, 1, 3, 0);
    for (int i = 0; i < 6; i++) begin
      runReq(int'($urandom % 64), 1 + int'($urandom % 4), int'($urandom % 4), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule